// File: doc/BRIEF.md
# Transmit Command Controller for a Short-Frame Serial Bus

This block sits between a byte-wide register port and a bit-level serial engine that sends short frames on a shared single-wire bus. Software fills a 16-byte frame store through the register port. The first byte is the header and the second is the opcode. Software then writes the frame size minus one into a length register and issues a 2-bit command. The controller waits until the bus has been quiet for a programmable signal-free time. It then pulses a start strobe to the bit engine, which reads the frame through an index/byte port. When the engine reports the outcome, the controller updates a 2-bit status code and raises a transmit interrupt.

A command takes effect only when the command register moves from no-op to a non-zero code. Software must therefore write no-op back before each new request. An abort stops an attempt that is still waiting or already transmitting. Three signal-free times are held as 11-bit values, each split over a low-byte register and a high-bits register:
- next-transfer, used by the send-next command;
- new-initiator, used by send-current after a successful attempt;
- retry, used by send-current after a failed attempt.

The state machine has three states:
- IDLE: no attempt in progress.
- WAIT: counting bus-idle cycles.
- XMIT: the engine owns the bus.

Its transitions are:
- IDLE→WAIT on a send command.
- WAIT→XMIT when the signal-free time is met.
- WAIT→IDLE and XMIT→IDLE on abort.
- XMIT→IDLE on engine completion.

Top module: `tx_cmd_ctrl`

## Requirements
- R1: Frame bytes written at addresses 0x00..0x0F read back at those addresses and appear on `eng_byte` when `eng_idx` selects them. The 4-bit length written at 0x10 reads back at 0x10 and drives `eng_len`.
- R2: While bit 0 of the clear register at 0x13 is 1, every frame byte and the length read 0 and writes to them are discarded. After 0 is written to 0x13 they stay 0 until rewritten, and new writes are accepted again.
- R3: The command register at 0x11 takes codes 0 no-op, 1 send-current, 2 abort and 3 send-next. A write starts an action only if the register held 0 before and the new code is non-zero. Rewriting the same code starts nothing.
- R4: After send-current, `eng_start` pulses for exactly one cycle once `bus_idle` has been high for N consecutive cycles. N is the new-initiator time, or the retry time if the last attempt did not end in acknowledge. The pulse appears N+1 cycles after the command's write edge.
- R5: Send-next uses the next-transfer time in place of N.
- R6: Any cycle with `bus_idle` low restarts the idle count from zero.
- R7: The status register at 0x93 reads 0 (idle) after reset and 1 (busy) from the command until the outcome. Engine result 0 (acknowledge) gives 2 (done), result 1 (no acknowledge) gives 3 (error), and result 2 (arbitration lost) leaves 1.
- R8: `tx_irq` is set in the cycle after an attempt ends and stays set until `irq_ack` is pulsed.
- R9: Abort during WAIT or XMIT pulses `eng_abort`, sets the status to 3, raises `tx_irq` and returns to IDLE. Abort in IDLE changes neither the status nor `tx_irq`, and `eng_abort` stays low.
- R10: Signal-free times are 11 bits. The low byte is at 0x40 (next-transfer), 0x42 (new-initiator) or 0x44 (retry), and bits 10:8 are at the following address in bits 2:0. The reset values are 0x2AA, 0x000 and 0x118 respectively.
- R11: A send command that arrives while an attempt is in WAIT or XMIT is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 8 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_ack | input | 1 | Clears the transmit interrupt |
| tx_irq | output | 1 | Transmit-ended interrupt |
| bus_idle | input | 1 | Bus is quiet this cycle |
| eng_start | output | 1 | Start pulse to the bit engine |
| eng_abort | output | 1 | Stop pulse to the bit engine |
| eng_len | output | 4 | Frame size minus one |
| eng_idx | input | 4 | Frame byte index from the engine |
| eng_byte | output | 8 | Selected frame byte |
| eng_done | input | 1 | Engine reports end of attempt |
| eng_result | input | 2 | Outcome: 0 ack, 1 nack, 2 arbitration lost |

## Verification
Register reads are combinational, so a write shows on the read port at the first falling edge after its write edge. The status, `tx_irq` and `eng_abort` results follow a write or an `eng_done` pulse by exactly one clock edge, and the bench samples them at the falling edge that follows. The start delay is measured by counting falling edges after the command's write edge, and a signal-free time of N must give exactly N+1. The bus-idle restart case therefore expects a larger count computed from where `bus_idle` dropped. The bench also watches for spurious start or abort pulses over fixed windows after commands that must be ignored.

// File: rtl/cec_txc_pkg.sv
package cec_txc_pkg;
    typedef enum logic [1:0] {CMD_NOP = 2'd0, CMD_SEND = 2'd1, CMD_ABORT = 2'd2, CMD_NEXT = 2'd3} cmd_e;
    typedef enum logic [1:0] {STS_IDLE = 2'd0, STS_BUSY = 2'd1, STS_DONE = 2'd2, STS_ERR = 2'd3} status_e;
    typedef enum logic [1:0] {RES_ACK = 2'd0, RES_NACK = 2'd1, RES_ARB = 2'd2, RES_RSV = 2'd3} result_e;
    typedef enum logic [1:0] {SFT_NEXT = 2'd0, SFT_NEWINIT = 2'd1, SFT_RETRY = 2'd2} sft_sel_e;
    typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_WAIT = 2'd1, FS_XMIT = 2'd2} fsm_e;

    localparam logic [7:0] ADR_LEN    = 8'h10;
    localparam logic [7:0] ADR_CMD    = 8'h11;
    localparam logic [7:0] ADR_CLR    = 8'h13;
    localparam logic [7:0] ADR_SFT    = 8'h40;
    localparam logic [7:0] ADR_STATUS = 8'h93;
endpackage

// File: rtl/tx_msg_store.sv
module tx_msg_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [7:0]    rd_addr,
    input  logic [AW-1:0] eng_idx,
    output logic [DW-1:0] eng_byte,
    output logic [DW-1:0] rd_byte,
    output logic          rd_hit,
    output logic [AW-1:0] len_q,
    output logic          clr_q
);
    import cec_txc_pkg::*;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= 1'b0;
            len_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_CLR) clr_q <= wr_data[0];
            if (clr_q) begin
                len_q <= '0;
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADR_LEN) len_q <= wr_data[AW-1:0];
                for (int i = 0; i < DEPTH; i++)
                    if (wr_addr == 8'(i)) mem[i] <= wr_data;
            end
        end
    end

    assign eng_byte = mem[eng_idx];

    always_comb begin
        rd_hit  = 1'b0;
        rd_byte = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == 8'(i)) begin
                rd_hit  = 1'b1;
                rd_byte = mem[i];
            end
        end
        if (rd_addr == ADR_LEN) begin
            rd_hit  = 1'b1;
            rd_byte = DW'(len_q);
        end
    end

    // R2
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && $past(clr_q)) |-> (len_q == '0 && mem[0] == '0));
endmodule

// File: rtl/tx_sft_timer.sv
module tx_sft_timer #(
    parameter int          TW        = 11,
    parameter logic [10:0] RST_NEXT  = 11'h2AA,
    parameter logic [10:0] RST_NEW   = 11'h000,
    parameter logic [10:0] RST_RETRY = 11'h118,
    localparam int         NSEL      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    input  cec_txc_pkg::sft_sel_e sel,
    input  logic                  run,
    input  logic                  bus_idle,
    output logic                  ready,
    output logic [7:0]            rd_val,
    output logic                  rd_hit
);
    import cec_txc_pkg::*;

    logic [TW-1:0] sft [NSEL];
    logic [TW-1:0] cnt;

    function automatic logic [TW-1:0] rst_val(int idx);
        case (idx)
            0:       return TW'(RST_NEXT);
            1:       return TW'(RST_NEW);
            default: return TW'(RST_RETRY);
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEL; i++) sft[i] <= rst_val(i);
        end else if (wr_en) begin
            for (int i = 0; i < NSEL; i++) begin
                if (wr_addr == 8'(ADR_SFT + 8'(2*i)))     sft[i][7:0]    <= wr_data;
                if (wr_addr == 8'(ADR_SFT + 8'(2*i + 1))) sft[i][TW-1:8] <= wr_data[TW-9:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || !bus_idle) cnt <= '0;
        else if (cnt != '1)        cnt <= cnt + 1'b1;
    end

    assign ready = run && bus_idle && (cnt >= sft[sel]);

    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (rd_addr == 8'(ADR_SFT + 8'(2*i))) begin
                rd_hit = 1'b1;
                rd_val = sft[i][7:0];
            end
            if (rd_addr == 8'(ADR_SFT + 8'(2*i + 1))) begin
                rd_hit = 1'b1;
                rd_val = 8'(sft[i][TW-1:8]);
            end
        end
    end

    // R6
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> bus_idle);
    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> cnt == '0);
endmodule

// File: rtl/tx_cmd_fsm.sv
module tx_cmd_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  cec_txc_pkg::cmd_e     go_cmd,
    input  logic                  ready,
    input  logic                  eng_done,
    input  cec_txc_pkg::result_e  eng_result,
    input  logic                  irq_ack,
    output cec_txc_pkg::fsm_e     state,
    output cec_txc_pkg::status_e  status,
    output cec_txc_pkg::sft_sel_e sel,
    output logic                  eng_start,
    output logic                  eng_abort,
    output logic                  irq
);
    import cec_txc_pkg::*;

    fsm_e nxt;
    logic last_fail;
    logic do_abort;
    logic do_send;

    assign do_abort  = go && go_cmd == CMD_ABORT && state != FS_IDLE;
    assign do_send   = go && (go_cmd == CMD_SEND || go_cmd == CMD_NEXT) && state == FS_IDLE;
    assign eng_start = state == FS_WAIT && ready && !do_abort;

    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE: if (do_send) nxt = FS_WAIT;
            FS_WAIT: begin
                if (do_abort)   nxt = FS_IDLE;
                else if (ready) nxt = FS_XMIT;
            end
            FS_XMIT: if (do_abort || eng_done) nxt = FS_IDLE;
            default: nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= STS_IDLE;
            sel       <= SFT_NEWINIT;
            eng_abort <= 1'b0;
            irq       <= 1'b0;
            last_fail <= 1'b0;
        end else begin
            eng_abort <= 1'b0;
            if (irq_ack) irq <= 1'b0;
            if (do_send) begin
                status <= STS_BUSY;
                if (go_cmd == CMD_NEXT) sel <= SFT_NEXT;
                else                    sel <= last_fail ? SFT_RETRY : SFT_NEWINIT;
            end
            if (do_abort) begin
                status    <= STS_ERR;
                eng_abort <= 1'b1;
                irq       <= 1'b1;
                last_fail <= 1'b1;
            end else if (state == FS_XMIT && eng_done) begin
                irq <= 1'b1;
                unique case (eng_result)
                    RES_ACK:  begin status <= STS_DONE; last_fail <= 1'b0; end
                    RES_ARB:  begin status <= STS_BUSY; last_fail <= 1'b1; end
                    default:  begin status <= STS_ERR;  last_fail <= 1'b1; end
                endcase
            end
        end
    end

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    // R7
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FS_IDLE) |-> status == STS_BUSY);
    // R9
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> (status == STS_ERR && irq && state == FS_IDLE));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state) != FS_IDLE);
endmodule

// File: rtl/tx_cmd_ctrl.sv
module tx_cmd_ctrl #(
    parameter int DEPTH = 16,
    parameter int TW    = 11,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_raddr,
    output logic [7:0]    reg_rdata,
    input  logic          irq_ack,
    output logic          tx_irq,
    input  logic          bus_idle,
    output logic          eng_start,
    output logic          eng_abort,
    output logic [AW-1:0] eng_len,
    input  logic [AW-1:0] eng_idx,
    output logic [7:0]    eng_byte,
    input  logic          eng_done,
    input  logic [1:0]    eng_result
);
    import cec_txc_pkg::*;

    cmd_e     cmd_q;
    logic     go;
    fsm_e     state;
    status_e  status;
    sft_sel_e sel;
    logic     ready;
    logic     clr_q;
    logic     buf_hit, tmr_hit;
    logic [7:0] buf_rd, tmr_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cmd_q <= CMD_NOP;
        else if (reg_wr && reg_addr == ADR_CMD) cmd_q <= cmd_e'(reg_wdata[1:0]);
    end

    assign go = reg_wr && reg_addr == ADR_CMD && cmd_q == CMD_NOP && reg_wdata[1:0] != 2'd0;

    tx_msg_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .eng_idx(eng_idx), .eng_byte(eng_byte), .rd_byte(buf_rd),
        .rd_hit(buf_hit), .len_q(eng_len), .clr_q(clr_q)
    );

    tx_sft_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
        .rd_addr(reg_raddr), .sel(sel), .run(state == FS_WAIT), .bus_idle(bus_idle),
        .ready(ready), .rd_val(tmr_rd), .rd_hit(tmr_hit)
    );

    tx_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .go_cmd(cmd_e'(reg_wdata[1:0])), .ready(ready),
        .eng_done(eng_done), .eng_result(result_e'(eng_result)), .irq_ack(irq_ack),
        .state(state), .status(status), .sel(sel), .eng_start(eng_start),
        .eng_abort(eng_abort), .irq(tx_irq)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (buf_hit)                  reg_rdata = buf_rd;
        else if (tmr_hit)             reg_rdata = tmr_rd;
        else if (reg_raddr == ADR_CMD)    reg_rdata = {6'd0, cmd_q};
        else if (reg_raddr == ADR_CLR)    reg_rdata = {7'd0, clr_q};
        else if (reg_raddr == ADR_STATUS) reg_rdata = {6'd0, status};
    end

    // R3
    repeat_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_CMD && cmd_q != CMD_NOP && state == FS_IDLE) |=> state == FS_IDLE);
endmodule

// File: tb/sim_tx_cmd_ctrl.sv
module sim_tx_cmd_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, irq_ack = 1'b0, bus_idle = 1'b1, eng_done = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_raddr = '0, reg_rdata, eng_byte;
    logic [3:0] eng_idx = '0, eng_len;
    logic [1:0] eng_result = '0;
    logic tx_irq, eng_start, eng_abort;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tx_cmd_ctrl u0 (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_raddr = a; #1; v = reg_rdata;
    endtask

    task automatic wait_start(output int gap);
        gap = 1;
        while (!eng_start && gap < 200) begin @(negedge clk); gap++; end
    endtask

    task automatic finish_attempt(input logic [1:0] res);
        @(negedge clk); eng_done = 1'b1; eng_result = res;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic no_pulse(string tag, int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            if (eng_start || eng_abort) seen++;
            @(negedge clk);
        end
        chk(tag, seen, 0);
    endtask

    task automatic t_reset();
        int v;
        rd(8'h93, v); chk("R7 reset status", v, 0);
        chk("R8 reset irq", tx_irq, 0);
        rd(8'h40, v); chk("R10 next lo", v, 8'hAA);
        rd(8'h41, v); chk("R10 next hi", v, 8'h02);
        rd(8'h42, v); chk("R10 newinit lo", v, 0);
        rd(8'h44, v); chk("R10 retry lo", v, 8'h18);
        rd(8'h45, v); chk("R10 retry hi", v, 8'h01);
    endtask

    task automatic t_buffer();
        int v;
        for (int i = 0; i < 16; i++) wr(8'(i), 8'(8'h30 + i));
        wr(8'h10, 8'h04);
        rd(8'h00, v); chk("R1 header", v, 8'h30);
        rd(8'h0F, v); chk("R1 last byte", v, 8'h3F);
        rd(8'h10, v); chk("R1 length", v, 4);
        chk("R1 eng_len", eng_len, 4);
        eng_idx = 4'd7; #1; chk("R1 eng_byte", eng_byte, 8'h37);
    endtask

    task automatic t_program();
        int v;
        wr(8'h42, 8'd3); wr(8'h44, 8'd5); wr(8'h45, 8'd0);
        wr(8'h40, 8'd7); wr(8'h41, 8'd0);
        rd(8'h44, v); chk("R10 retry write", v, 5);
        rd(8'h41, v); chk("R10 next hi write", v, 0);
    endtask

    task automatic t_send_ack();
        int g, v;
        wr(8'h11, 8'd1);
        rd(8'h93, v); chk("R7 busy", v, 1);
        wait_start(g); chk("R4 newinit gap", g, 4);
        @(negedge clk); chk("R4 single pulse", eng_start, 0);
        finish_attempt(2'd0);
        rd(8'h93, v); chk("R7 done on ack", v, 2);
        chk("R8 irq set", tx_irq, 1);
        ack_irq(); chk("R8 irq cleared", tx_irq, 0);
        wr(8'h11, 8'd1);
        no_pulse("R3 repeat write", 20);
        rd(8'h93, v); chk("R3 status kept", v, 2);
    endtask

    task automatic t_nack_retry();
        int g, v;
        wr(8'h11, 8'd0); wr(8'h11, 8'd1);
        wait_start(g); chk("R4 gap after ack", g, 4);
        finish_attempt(2'd1);
        rd(8'h93, v); chk("R7 error on nack", v, 3);
        ack_irq();
        wr(8'h11, 8'd0); wr(8'h11, 8'd1);
        wait_start(g); chk("R4 retry gap", g, 6);
        finish_attempt(2'd2);
        rd(8'h93, v); chk("R7 busy on arb lost", v, 1);
        chk("R8 irq on arb lost", tx_irq, 1);
        ack_irq();
    endtask

    task automatic t_next();
        int g, v;
        wr(8'h11, 8'd0); wr(8'h11, 8'd3);
        wait_start(g); chk("R5 next gap", g, 8);
        wr(8'h11, 8'd0); wr(8'h11, 8'd1);
        no_pulse("R11 send while busy", 10);
        rd(8'h93, v); chk("R11 still busy", v, 1);
        finish_attempt(2'd0);
        rd(8'h93, v); chk("R7 done after next", v, 2);
        ack_irq();
    endtask

    task automatic t_restart_abort();
        int g, v;
        wr(8'h11, 8'd0); wr(8'h11, 8'd1);
        g = 1;
        while (!eng_start && g < 200) begin
            if (g == 2) bus_idle = 1'b0;
            if (g == 3) bus_idle = 1'b1;
            @(negedge clk); g++;
        end
        chk("R6 restarted gap", g, 6);
        wr(8'h11, 8'd0); wr(8'h11, 8'd2);
        chk("R9 abort pulse", eng_abort, 1);
        rd(8'h93, v); chk("R9 error status", v, 3);
        chk("R9 irq", tx_irq, 1);
        ack_irq();
        wr(8'h11, 8'd0); wr(8'h11, 8'd2);
        no_pulse("R9 idle abort pulse", 5);
        rd(8'h93, v); chk("R9 idle abort status", v, 3);
        chk("R9 idle abort irq", tx_irq, 0);
    endtask

    task automatic t_clear();
        int v;
        wr(8'h13, 8'd1);
        wr(8'h02, 8'h55);
        rd(8'h02, v); chk("R2 write discarded", v, 0);
        rd(8'h00, v); chk("R2 byte cleared", v, 0);
        rd(8'h10, v); chk("R2 length cleared", v, 0);
        wr(8'h13, 8'd0);
        rd(8'h0F, v); chk("R2 stays empty", v, 0);
        wr(8'h03, 8'h66);
        rd(8'h03, v); chk("R2 write after release", v, 8'h66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buffer();
        t_program();
        t_send_ack();
        t_nack_retry();
        t_next();
        t_restart_abort();
        t_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule